// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time

This block drives a three-phase inverter bridge. A triangle carrier counts up from the dead-time value to the period value and back down. Each phase compares the carrier with its own duty value. The raw result is then split into a positive and a negative output, and both outputs are held inactive for a programmable dead time around every switch, so the two switches of a bridge leg are never on together. Duty values are written into a buffer and copied to the active compare only at a chosen carrier turning point, which keeps the pulses symmetric when software updates the duty in mid-cycle.

The carrier is advanced by a prescaled tick. At its two turning points the block raises single-cycle crest and trough interrupt strobes, and either strobe can be thinned to one every N events. A third strobe starts an A/D conversion at a programmable carrier value while the carrier counts down, with its own thinning ratio. All settings are written over a simple write-only register bus. With the default parameters the block has 3 phases, a 16-bit carrier and 3-bit skip fields.

Top module: `tri_pwm`

## Requirements
- R1: For each phase, the raw drive is active while the carrier value is strictly greater than that phase's active duty. The positive output follows the raw drive and the negative output follows its complement, and the two outputs of a phase are never active in the same cycle.
- R2: After every change of a phase's raw drive, both outputs of that phase stay inactive until DT carrier ticks have passed (DT is the dead-time register). At divide-by-1 with carrier period P = 2*(PERIOD-DT) and raw high for H ticks per period, the positive output is active H-DT cycles per period and the negative output P-H-DT cycles. With DT = 0, the outputs switch without a gap.
- R3: If the raw drive changes again before the dead time has run out, the countdown restarts, so a raw pulse shorter than DT gives no active output on either side until DT ticks after the last change.
- R4: Duty writes go to a buffer. The active duty takes the buffered value only at the load point chosen by CTRL[2:1]: 0 = crest, 1 = trough, 2 or 3 = both. While stopped, the buffer is copied every cycle.
- R5: A duty value at or above PERIOD gives 0 %: the positive output is never active and the negative output is steady. A duty value below DT gives 100 %: the positive output is steady and the negative output is never active.
- R6: The carrier turns at PERIOD and at DT. irq_crest is a one-cycle strobe per crest, irq_trough is a one-cycle strobe per trough, and at divide-by-1 irq_trough follows irq_crest by PERIOD-DT cycles.
- R7: The skip field SKIP[2:0] = K makes each of irq_crest and irq_trough fire on one event out of every K+1, starting with the first event after run is set.
- R8: adc_trig pulses for one cycle when the carrier equals the ADC compare register while counting down. At divide-by-1 this is PERIOD-ADC cycles after irq_crest. SKIP[5:3] = K keeps one trigger in every K+1.
- R9: CTRL[6:3] selects the carrier tick divider: values 0 to 6 give 1, 2, 4, 8, 16, 32 and 64, value 7 gives 256, and values 8 and above give 1024.
- R10: In reset and while CTRL[0] (run) is 0, all six PWM outputs and all three strobes are low, and the carrier is held at DT counting up.
- R11: Register addresses: 0 = PERIOD, 1 = DT, 2 = CTRL, 3 = SKIP, 4 = ADC compare, 5 + i = duty buffer of phase i. A write takes effect at the clock edge where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Register write data |
| pwm_pos | output | NPH | Positive (high-side) output per phase |
| pwm_neg | output | NPH | Negative (low-side) output per phase |
| irq_crest | output | 1 | Crest interrupt strobe |
| irq_trough | output | 1 | Trough interrupt strobe |
| adc_trig | output | 1 | A/D conversion start strobe |

## Verification
Four properties are checked on every cycle:
- the two outputs of a phase never overlap;
- while a nonzero dead time is set, an active output is never followed directly by its complement;
- the active duty never moves outside a load point;
- crest and trough strobes last one cycle and never coincide.

The exact dead-time widths, the suppression of narrow pulses, the 0 % and 100 % extremes, the skip ratios, the trigger delay and the prescaler divide values can only be shown by the bench. It measures active counts, strobe counts and strobe distances over whole carrier periods and compares them with values derived from PERIOD, DT and the duty.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;
   localparam int A_PERIOD = 0;
   localparam int A_DEAD   = 1;
   localparam int A_CTRL   = 2;
   localparam int A_SKIP   = 3;
   localparam int A_ADC    = 4;
   localparam int A_DUTY0  = 5;

   typedef enum logic [1:0] {
      LD_CREST  = 2'd0,
      LD_TROUGH = 2'd1,
      LD_BOTH   = 2'd2,
      LD_BOTH_B = 2'd3
   } load_sel_e;

   function automatic int unsigned div_of(input logic [3:0] sel);
      if (sel <= 4'd6) return 32'd1 << sel;
      else if (sel == 4'd7) return 32'd256;
      else return 32'd1024;
   endfunction
endpackage

// File: rtl/tri_pwm_prescale.sv
module tri_pwm_prescale
   import tri_pwm_pkg::*;
#(
   parameter int PRE_W = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [3:0] sel,
   output logic       tick
);
   if (PRE_W < 10) begin : g_bad_pre
      $error("PRE_W must hold a divide by 1024");
   end

   logic [PRE_W-1:0] cnt;
   logic [PRE_W-1:0] lim;

   assign lim  = PRE_W'(div_of(sel) - 32'd1);
   assign tick = run && (cnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else cnt <= cnt + PRE_W'(1);
   end
endmodule

// File: rtl/tri_pwm_carrier.sv
module tri_pwm_carrier #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] top,
   input  logic [CNT_W-1:0] dt,
   output logic [CNT_W-1:0] cnt,
   output logic             down,
   output logic             crest_evt,
   output logic             trough_evt
);
   assign crest_evt  = tick && !down && (cnt >= top);
   assign trough_evt = tick &&  down && (cnt <= dt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         down <= 1'b0;
      end else if (!run) begin
         cnt  <= dt;
         down <= 1'b0;
      end else if (crest_evt) begin
         down <= 1'b1;
         if (cnt > dt) cnt <= cnt - CNT_W'(1);
      end else if (trough_evt) begin
         down <= 1'b0;
         if (cnt < top) cnt <= cnt + CNT_W'(1);
      end else if (tick) begin
         cnt <= down ? cnt - CNT_W'(1) : cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/tri_pwm_dtpair.sv
module tri_pwm_dtpair #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             raw,
   input  logic [CNT_W-1:0] dt,
   output logic             pos,
   output logic             neg
);
   logic             raw_q;
   logic [CNT_W-1:0] dtc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
         dtc   <= '0;
      end else begin
         raw_q <= raw;
         if (!run || (raw != raw_q)) dtc <= dt;
         else if (tick && (dtc != '0)) dtc <= dtc - CNT_W'(1);
      end
   end

   assign pos = run && (dtc == '0) &&  raw_q;
   assign neg = run && (dtc == '0) && !raw_q;
endmodule

// File: rtl/tri_pwm_skip.sv
module tri_pwm_skip #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         evt,
   input  logic [W-1:0] limit,
   output logic         strobe
);
   logic [W-1:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen   <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= 1'b0;
         if (!run) begin
            seen <= '0;
         end else if (evt) begin
            if (seen >= limit) begin
               seen   <= '0;
               strobe <= 1'b1;
            end else begin
               seen <= seen + W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/tri_pwm.sv
module tri_pwm
   import tri_pwm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NPH    = 3,
   parameter int SKIP_W = 3,
   parameter int PRE_W  = 10,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [NPH-1:0]    pwm_pos,
   output logic [NPH-1:0]    pwm_neg,
   output logic              irq_crest,
   output logic              irq_trough,
   output logic              adc_trig
);
   localparam int CTRL_W = 7;
   localparam int NREG   = A_DUTY0 + NPH;
   localparam int NSTR   = 3;

   if (CNT_W < CTRL_W || CNT_W < 2 * SKIP_W) begin : g_bad_w
      $error("CNT_W too narrow for the control fields");
   end
   if (NREG > (1 << ADDR_W)) begin : g_bad_a
      $error("ADDR_W too small for the phase count");
   end

   logic [CNT_W-1:0]            top_q, dt_q, adc_q;
   logic [CTRL_W-1:0]           ctrl_q;
   logic [2*SKIP_W-1:0]         skip_q;
   logic [NPH-1:0][CNT_W-1:0]   duty_buf, duty_act;

   logic        run;
   load_sel_e   ld_sel;
   logic [3:0]  clk_sel;
   assign run     = ctrl_q[0];
   assign ld_sel  = load_sel_e'(ctrl_q[2:1]);
   assign clk_sel = ctrl_q[6:3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_q    <= '0;
         dt_q     <= '0;
         adc_q    <= '0;
         ctrl_q   <= '0;
         skip_q   <= '0;
         duty_buf <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(A_PERIOD)) top_q  <= wr_data;
         if (wr_addr == ADDR_W'(A_DEAD))   dt_q   <= wr_data;
         if (wr_addr == ADDR_W'(A_CTRL))   ctrl_q <= wr_data[CTRL_W-1:0];
         if (wr_addr == ADDR_W'(A_SKIP))   skip_q <= wr_data[2*SKIP_W-1:0];
         if (wr_addr == ADDR_W'(A_ADC))    adc_q  <= wr_data;
         for (int i = 0; i < NPH; i++) begin
            if (wr_addr == ADDR_W'(A_DUTY0 + i)) duty_buf[i] <= wr_data;
         end
      end
   end

   logic             tick, down, crest_evt, trough_evt, adc_evt, load_now;
   logic [CNT_W-1:0] cnt;

   tri_pwm_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .sel(clk_sel), .tick(tick)
   );

   tri_pwm_carrier #(.CNT_W(CNT_W)) u_car (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
      .top(top_q), .dt(dt_q), .cnt(cnt), .down(down),
      .crest_evt(crest_evt), .trough_evt(trough_evt)
   );

   assign adc_evt = tick && down && (cnt == adc_q);

   always_comb begin
      case (ld_sel)
         LD_CREST:  load_now = crest_evt;
         LD_TROUGH: load_now = trough_evt;
         default:   load_now = crest_evt || trough_evt;
      endcase
      if (!run) load_now = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) duty_act <= '0;
      else if (load_now) duty_act <= duty_buf;
   end

   logic [NSTR-1:0]  str_evt, str_out;
   logic [SKIP_W-1:0] str_lim [NSTR];
   assign str_evt    = {adc_evt, trough_evt, crest_evt};
   assign str_lim[0] = skip_q[SKIP_W-1:0];
   assign str_lim[1] = skip_q[SKIP_W-1:0];
   assign str_lim[2] = skip_q[2*SKIP_W-1:SKIP_W];

   for (genvar k = 0; k < NSTR; k++) begin : g_str
      tri_pwm_skip #(.W(SKIP_W)) u_skip (
         .clk(clk), .rst_n(rst_n), .run(run), .evt(str_evt[k]),
         .limit(str_lim[k]), .strobe(str_out[k])
      );
   end

   assign irq_crest  = str_out[0];
   assign irq_trough = str_out[1];
   assign adc_trig   = str_out[2];

   for (genvar p = 0; p < NPH; p++) begin : g_ph
      logic raw;
      assign raw = cnt > duty_act[p];
      tri_pwm_dtpair #(.CNT_W(CNT_W)) u_dt (
         .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .raw(raw),
         .dt(dt_q), .pos(pwm_pos[p]), .neg(pwm_neg[p])
      );
   end
endmodule

// File: rtl/tri_pwm_chk.sv
module tri_pwm_chk #(
   parameter int CNT_W = 16,
   parameter int NPH   = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      run,
   input logic                      load_now,
   input logic [CNT_W-1:0]          dt_q,
   input logic [NPH-1:0][CNT_W-1:0] duty_act,
   input logic [NPH-1:0]            pos,
   input logic [NPH-1:0]            neg,
   input logic                      irq_crest,
   input logic                      irq_trough
);
   // R1: a phase never drives both switches at once
   p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pos & neg) == '0);

   for (genvar p = 0; p < NPH; p++) begin : g_gap
      // R2: with a nonzero dead time an output is never followed by its complement
      p_gap_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ((dt_q != '0) && pos[p]) |=> !neg[p]);
      p_gap_neg_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ((dt_q != '0) && neg[p]) |=> !pos[p]);
   end

   // R4: the active duty moves only at a load point
   p_buf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load_now) |=> $stable(duty_act));

   // R6: turning-point strobes last one cycle and never coincide
   p_crest_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_crest |=> !irq_crest);
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_crest, irq_trough}));
endmodule

bind tri_pwm tri_pwm_chk #(.CNT_W(CNT_W), .NPH(NPH)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .load_now(load_now), .dt_q(dt_q),
   .duty_act(duty_act), .pos(pwm_pos), .neg(pwm_neg),
   .irq_crest(irq_crest), .irq_trough(irq_trough)
);

// File: tb/tri_pwm_tb.sv
`timescale 1ns/1ps
module tri_pwm_tb;
   localparam int CNT_W = 16;
   localparam int NPH   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic [NPH-1:0]    pwm_pos, pwm_neg;
   logic              irq_crest, irq_trough, adc_trig;

   always #4 clk = ~clk;

   tri_pwm u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_pos(pwm_pos), .pwm_neg(pwm_neg),
      .irq_crest(irq_crest), .irq_trough(irq_trough), .adc_trig(adc_trig)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 0;

   typedef struct {
      string req;
      string what;
      int    exp;
   } item_t;
   item_t sbq[$];

   // driver side: queue what the requirements predict
   task automatic expect_item(input string req, input string what, input int exp);
      item_t it;
      it.req = req; it.what = what; it.exp = exp;
      sbq.push_back(it);
   endtask

   // monitor side: pop the oldest prediction and compare with the observation
   task automatic observe(input int act);
      item_t it;
      it = sbq.pop_front();
      total++;
      if (act != it.exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", it.req, it.what, act, it.exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(addr); wr_data = CNT_W'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic strobe(input int k);
      case (k)
         0: return irq_crest;
         1: return irq_trough;
         default: return adc_trig;
      endcase
   endfunction

   task automatic wait_strobe(input int k);
      do @(negedge clk); while (!strobe(k));
   endtask

   task automatic gap(input int a, input int b, output int n);
      wait_strobe(a);
      n = 0;
      do begin @(negedge clk); n++; end while (!strobe(b));
   endtask

   int pc[NPH], nc[NPH];
   int ov, ncr, ntr, nad;
   task automatic window(input int n);
      for (int i = 0; i < NPH; i++) begin pc[i] = 0; nc[i] = 0; end
      ov = 0; ncr = 0; ntr = 0; nad = 0;
      for (int t = 0; t < n; t++) begin
         @(negedge clk);
         for (int i = 0; i < NPH; i++) begin
            pc[i] += int'(pwm_pos[i]);
            nc[i] += int'(pwm_neg[i]);
            if (pwm_pos[i] && pwm_neg[i]) ov++;
         end
         ncr += int'(irq_crest);
         ntr += int'(irq_trough);
         nad += int'(adc_trig);
      end
   endtask

   // R11 register map
   localparam int RA_PER = 0, RA_DT = 1, RA_CTRL = 2, RA_SKIP = 3, RA_ADC = 4, RA_D0 = 5;

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R10 reset state
      expect_item("R10", "pos outputs in reset", 0); observe(int'(pwm_pos));
      expect_item("R10", "neg outputs in reset", 0); observe(int'(pwm_neg));
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      expect_item("R10", "strobes while stopped", 0);
      observe(int'({irq_crest, irq_trough, adc_trig}));

      // PERIOD 20, DT 2, P = 36 ticks, div 1
      wr(RA_PER, 20); wr(RA_DT, 2); wr(RA_ADC, 10); wr(RA_SKIP, 0);
      wr(RA_D0, 10); wr(RA_D0 + 1, 0); wr(RA_D0 + 2, 20);
      expect_item("R10", "neg held low while stopped", 0); observe(int'(pwm_neg));
      wr(RA_CTRL, 1);
      repeat (100) @(negedge clk);
      window(36);
      expect_item("R2", "phase0 pos cycles (H=19)", 17); observe(pc[0]);
      expect_item("R2", "phase0 neg cycles", 15);        observe(nc[0]);
      expect_item("R1", "overlap cycles", 0);            observe(ov);
      expect_item("R5", "phase1 100% pos", 36);          observe(pc[1]);
      expect_item("R5", "phase1 100% neg", 0);           observe(nc[1]);
      expect_item("R5", "phase2 0% pos", 0);             observe(pc[2]);
      expect_item("R5", "phase2 0% neg", 36);            observe(nc[2]);
      expect_item("R6", "crest strobes per period", 1);  observe(ncr);
      expect_item("R6", "trough strobes per period", 1); observe(ntr);
      expect_item("R8", "adc strobes per period", 1);    observe(nad);
      gap(0, 1, n);
      expect_item("R6", "crest to trough cycles", 18);   observe(n);
      gap(0, 2, n);
      expect_item("R8", "crest to adc cycles", 10);      observe(n);

      // R7 / R8 skip: irq every 3rd event, adc every 2nd
      wr(RA_CTRL, 0); wr(RA_SKIP, (1 << 3) | 2); wr(RA_CTRL, 1);
      repeat (80) @(negedge clk);
      window(216);
      expect_item("R7", "crest strobes in 6 periods, K=2", 2);  observe(ncr);
      expect_item("R7", "trough strobes in 6 periods, K=2", 2); observe(ntr);
      expect_item("R8", "adc strobes in 6 periods, K=1", 3);    observe(nad);

      // R3 narrow pulse, DT 4: P = 32
      wr(RA_CTRL, 0); wr(RA_SKIP, 0); wr(RA_DT, 4);
      wr(RA_D0, 19); wr(RA_D0 + 1, 12); wr(RA_CTRL, 1);
      repeat (80) @(negedge clk);
      window(32);
      expect_item("R3", "short pulse pos cycles", 0);  observe(pc[0]);
      expect_item("R3", "short pulse neg cycles", 27); observe(nc[0]);
      expect_item("R2", "DT4 duty12 pos cycles", 11);  observe(pc[1]);
      expect_item("R2", "DT4 duty12 neg cycles", 13);  observe(nc[1]);

      // R4 double buffer, crest load
      wr(RA_CTRL, 0); wr(RA_DT, 2); wr(RA_D0, 0); wr(RA_CTRL, 1);
      repeat (80) @(negedge clk);
      wait_strobe(0);
      wr(RA_D0, 20);
      wait_strobe(1);
      @(negedge clk);
      expect_item("R4", "crest mode keeps old duty past trough", 1); observe(int'(pwm_pos[0]));
      wait_strobe(0);
      repeat (4) @(negedge clk);
      expect_item("R4", "crest mode new duty after crest", 1); observe(int'(pwm_neg[0]));
      // R4 trough load: CTRL = run | load trough
      wr(RA_CTRL, 1 | (1 << 1));
      wait_strobe(0);
      wr(RA_D0, 0);
      wait_strobe(1);
      @(negedge clk);
      expect_item("R4", "trough mode loads at trough", 0); observe(int'(pwm_neg[0]));

      // R9 prescaler: crest to crest = 36 * divider
      wr(RA_CTRL, 0); wr(RA_CTRL, 1 | (1 << 3));
      gap(0, 0, n);
      expect_item("R9", "div2 carrier period", 72); observe(n);
      wr(RA_CTRL, 0); wr(RA_CTRL, 1 | (3 << 3));
      gap(0, 0, n);
      expect_item("R9", "div8 carrier period", 288); observe(n);
      wr(RA_CTRL, 0); wr(RA_CTRL, 1 | (7 << 3));
      gap(0, 0, n);
      expect_item("R9", "div256 carrier period", 9216); observe(n);
      wr(RA_CTRL, 0); wr(RA_CTRL, 1 | (8 << 3));
      gap(0, 0, n);
      expect_item("R9", "div1024 carrier period", 36864); observe(n);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule